// File: doc/BRIEF.md
# Control Transfer Stage Handshake Unit

This block sits on the device side of a serial bus endpoint and decides how each decoded token is answered. Firmware steers it through three command bits: data-stage enable, status acknowledge and stall. The bus front end supplies single-cycle token events (SETUP, IN, OUT) and a host-acknowledge pulse. For each token the block returns a two-bit handshake code, plus the data toggle to place on an outgoing data packet. Endpoint 0 is the control endpoint. It tracks the stages of a control transfer: setup, an optional data stage in the direction announced with the SETUP token, and a status stage in the opposite direction. All other endpoints are plain data endpoints.

Command bits clear themselves when the protocol event they were waiting for happens. The data-stage enable clears when its OUT packet is accepted or its IN packet is acknowledged by the host. Status acknowledge clears when the status stage completes. A SETUP token clears all three bits of endpoint 0. Firmware writes are pulses that set or clear bits. The read port returns the status and stall bits, and it always returns zero for the data-stage enable.

Nothing streams through this unit. Tokens and firmware writes are plain single-cycle pulses with no back-pressure: the unit takes one token per cycle and answers every valid token one cycle later.

Top module: `ctl_handshake_unit`

## Requirements
- R1: Each token with `tok_kind` 00 (SETUP), 01 (IN) or 10 (OUT) produces `hs_valid` high for exactly one cycle, on the clock edge after the token. Kind 11 is reserved and produces no response.
- R2: `hs_code` is 00 for NAK, 01 for ACK or a data packet, 10 for a zero-length packet and 11 for STALL. `hs_toggle` is the packet's data toggle on 01 answers to IN and on 10 answers, and 0 on every other answer.
- R3: A SETUP on endpoint 0 is always answered 01, even when stalled or when command bits are set. It clears the stall, status-acknowledge and data-stage-enable bits of endpoint 0 and starts a new transfer, whose data direction is given by `tok_read_dir` (1 = device to host). A SETUP on any other endpoint is answered 11 and changes no state.
- R4: In a host-to-device transfer, an OUT on endpoint 0 is answered 01 only when data-stage enable is set and `rx_room[0]` is high. Otherwise it is answered 00. Data-stage enable clears after each such 01.
- R5: In a device-to-host transfer, an IN on endpoint 0 receives data (01) only when data-stage enable is set and `tx_ready[0]` is high. Otherwise it is answered 00. Data-stage enable clears when `host_ack` follows that data packet.
- R6: In the status stage (an IN in a host-to-device transfer, an OUT in a device-to-host transfer), status acknowledge 0 gives 00. Status acknowledge 1 gives 10 to an IN and 01 to an OUT. Status acknowledge may be set directly after SETUP when there is no data stage.
- R7: Status acknowledge clears when the status stage completes: on `host_ack` of the zero-length packet, or on the 01 answer to the status OUT. Endpoint 0 then answers IN and OUT with 00 until the next SETUP.
- R8: A set stall bit makes an endpoint answer IN and OUT with 11. On an endpoint marked isochronous (`ep_iso`), the stall bit has no effect.
- R9: Endpoint 0 is always enabled. A data endpoint with `ep_enable` low answers 00. An enabled data endpoint sends data (01) to IN when `tx_ready` is high and answers OUT with 01 when `rx_room` is high. Otherwise it answers 00.
- R10: A data endpoint's toggle starts at 0 and flips on each accepted OUT and on each host-acknowledged IN data packet. Stalling does not reset it. Only a low `ep_enable` returns it to 0. On endpoint 0, SETUP sets the toggle to 1 and a zero-length status packet always carries toggle 1.
- R11: `rd_bits` = {data-stage enable, status acknowledge, stall} of endpoint `rd_ep`. Bit 2 always reads 0. Bit 1 reads 0 for endpoints other than 0.
- R12: A firmware write takes effect on the clock edge, after the decision for a token in the same cycle. When a write and an automatic clear meet in one cycle, the write wins, except that a SETUP on endpoint 0 overrides a write to endpoint 0. Stall clear wins over stall set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fw_we | input | 1 | Firmware command write pulse |
| fw_ep | input | EPW | Endpoint addressed by the write |
| fw_dsen | input | 1 | Set data-stage enable (endpoint 0 only) |
| fw_status | input | 1 | Set status acknowledge (endpoint 0 only) |
| fw_stall_set | input | 1 | Set stall |
| fw_stall_clr | input | 1 | Clear stall |
| rd_ep | input | EPW | Endpoint selected for readback |
| rd_bits | output | 3 | {data-stage enable (reads 0), status acknowledge, stall} |
| ep_enable | input | NUM_EP-1 | Enable of data endpoints 1 and up |
| ep_iso | input | NUM_EP-1 | Isochronous marker of data endpoints 1 and up |
| tx_ready | input | NUM_EP | Validated transmit data present, per endpoint |
| rx_room | input | NUM_EP | Receive buffer has room, per endpoint |
| tok_valid | input | 1 | Token event pulse |
| tok_kind | input | 2 | 00 SETUP, 01 IN, 10 OUT, 11 reserved |
| tok_ep | input | EPW | Endpoint addressed by the token |
| tok_read_dir | input | 1 | With SETUP: 1 = data stage is device to host |
| host_ack | input | 1 | Host acknowledged the last packet sent |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | Handshake code |
| hs_toggle | output | 1 | Data toggle of the outgoing packet |

## Verification
Two events can land in the same cycle: a firmware command write and a protocol event that clears the same bit. The bench provokes the main cases on purpose. A SETUP arrives while firmware writes status and stall to endpoint 0, and is judged by the ACK answer and an all-zero readback. A host acknowledge of control data arrives together with a new data-stage-enable write, and the following IN must still get data. A stall write arrives alongside an IN to the same endpoint: the IN is answered from the old state and the next IN is stalled. Simultaneous stall set and clear must leave the stall bit clear.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    TK_SETUP = 2'b00,
    TK_IN    = 2'b01,
    TK_OUT   = 2'b10,
    TK_RSVD  = 2'b11
  } tok_kind_e;

  typedef enum logic [1:0] {
    HS_NAK   = 2'b00,
    HS_ACK   = 2'b01,
    HS_ZLP   = 2'b10,
    HS_STALL = 2'b11
  } hs_code_e;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'b00,
    CS_WRITE = 2'b01,
    CS_READ  = 2'b10
  } ctl_stage_e;

  // Protocol events produced by the decision for one token
  typedef struct packed {
    logic setup_ep0;        // SETUP accepted on the control endpoint
    logic out_data_ack;     // data OUT accepted (toggle flip, enable clear)
    logic status_out_done;  // status OUT accepted on control endpoint
    logic in_data;          // data packet sent, awaiting host acknowledge
    logic in_zlp;           // zero-length status packet sent
  } hs_event_t;

endpackage

// File: rtl/hs_decide.sv
module hs_decide
  import hs_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EPW    = $clog2(NUM_EP)
) (
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic [EPW-1:0]    tok_ep,
  input  logic [NUM_EP-1:1] ep_enable,
  input  logic [NUM_EP-1:1] ep_iso,
  input  logic [NUM_EP-1:0] tx_ready,
  input  logic [NUM_EP-1:0] rx_room,
  input  logic [NUM_EP-1:0] stall,
  input  logic              dsen0,
  input  logic              status0,
  input  ctl_stage_e        stage,
  input  logic [NUM_EP-1:0] tgl,
  output logic              resp_valid,
  output hs_code_e          resp_code,
  output logic              resp_toggle,
  output hs_event_t         ev
);

  logic [NUM_EP-1:0] en_full;
  logic [NUM_EP-1:0] iso_full;
  logic              is_ctl;
  logic              sel_en;
  logic              sel_stall;
  logic              sel_tx;
  logic              sel_rx;
  logic              sel_tgl;

  assign en_full   = {ep_enable, 1'b1};
  assign iso_full  = {ep_iso, 1'b0};
  assign is_ctl    = (tok_ep == '0);
  assign sel_en    = en_full[tok_ep];
  assign sel_stall = stall[tok_ep] && !iso_full[tok_ep];
  assign sel_tx    = tx_ready[tok_ep];
  assign sel_rx    = rx_room[tok_ep];
  assign sel_tgl   = tgl[tok_ep];

  always_comb begin
    resp_valid  = tok_valid && (tok_kind != TK_RSVD);
    resp_code   = HS_NAK;
    resp_toggle = 1'b0;
    ev          = '0;
    if (tok_valid) begin
      case (tok_kind)
        TK_SETUP: begin
          if (is_ctl) begin
            resp_code    = HS_ACK;
            ev.setup_ep0 = 1'b1;
          end else begin
            resp_code = HS_STALL;
          end
        end
        TK_IN: begin
          if (!is_ctl) begin
            if (!sel_en) begin
              resp_code = HS_NAK;
            end else if (sel_stall) begin
              resp_code = HS_STALL;
            end else if (sel_tx) begin
              resp_code   = HS_ACK;
              resp_toggle = sel_tgl;
              ev.in_data  = 1'b1;
            end
          end else if (sel_stall) begin
            resp_code = HS_STALL;
          end else if (stage == CS_READ) begin
            if (dsen0 && tx_ready[0]) begin
              resp_code   = HS_ACK;
              resp_toggle = tgl[0];
              ev.in_data  = 1'b1;
            end
          end else if (stage == CS_WRITE) begin
            if (status0) begin
              resp_code   = HS_ZLP;
              resp_toggle = 1'b1;
              ev.in_zlp   = 1'b1;
            end
          end
        end
        TK_OUT: begin
          if (!is_ctl) begin
            if (!sel_en) begin
              resp_code = HS_NAK;
            end else if (sel_stall) begin
              resp_code = HS_STALL;
            end else if (sel_rx) begin
              resp_code       = HS_ACK;
              ev.out_data_ack = 1'b1;
            end
          end else if (sel_stall) begin
            resp_code = HS_STALL;
          end else if (stage == CS_WRITE) begin
            if (dsen0 && rx_room[0]) begin
              resp_code       = HS_ACK;
              ev.out_data_ack = 1'b1;
            end
          end else if (stage == CS_READ) begin
            if (status0) begin
              resp_code          = HS_ACK;
              ev.status_out_done = 1'b1;
            end
          end
        end
        default: resp_code = HS_NAK;
      endcase
    end
  end

endmodule

// File: rtl/hs_cmd_bank.sv
module hs_cmd_bank #(
  parameter int NUM_EP = 4,
  parameter int EPW    = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fw_we,
  input  logic [EPW-1:0]    fw_ep,
  input  logic              fw_dsen,
  input  logic              fw_status,
  input  logic              fw_stall_set,
  input  logic              fw_stall_clr,
  input  logic              setup_ep0,
  input  logic              dsen_clr,
  input  logic              status_clr,
  output logic [NUM_EP-1:0] stall,
  output logic              dsen0,
  output logic              status0
);

  logic hit0;
  assign hit0 = fw_we && (fw_ep == '0) && !setup_ep0;

  // Control-endpoint-only bits: SETUP first, then firmware set, then auto clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsen0   <= 1'b0;
      status0 <= 1'b0;
    end else begin
      if (setup_ep0)              dsen0 <= 1'b0;
      else if (hit0 && fw_dsen)   dsen0 <= 1'b1;
      else if (dsen_clr)          dsen0 <= 1'b0;

      if (setup_ep0)              status0 <= 1'b0;
      else if (hit0 && fw_status) status0 <= 1'b1;
      else if (status_clr)        status0 <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_EP; i++) begin : g_stall
    logic hit;
    if (i == 0) begin : g_ctl
      assign hit = hit0;
      always_ff @(posedge clk) begin
        if (!rst_n)                    stall[i] <= 1'b0;
        else if (setup_ep0)            stall[i] <= 1'b0;
        else if (hit && fw_stall_clr)  stall[i] <= 1'b0;
        else if (hit && fw_stall_set)  stall[i] <= 1'b1;
      end
    end else begin : g_data
      assign hit = fw_we && (fw_ep == EPW'(i));
      always_ff @(posedge clk) begin
        if (!rst_n)                    stall[i] <= 1'b0;
        else if (hit && fw_stall_clr)  stall[i] <= 1'b0;
        else if (hit && fw_stall_set)  stall[i] <= 1'b1;
      end
    end
  end

  assert_setup_clears_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    setup_ep0 |=> (!dsen0 && !status0 && !stall[0]));

  assert_fw_dsen_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_we && fw_ep == '0 && fw_dsen && !setup_ep0) |=> dsen0);

  assert_status_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !(fw_we && fw_ep == '0 && fw_status)) |=> !status0);

endmodule

// File: rtl/hs_ctl_stage.sv
module hs_ctl_stage
  import hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       setup_ep0,
  input  logic       setup_read,
  input  logic       status_done,
  output ctl_stage_e stage
);

  always_ff @(posedge clk) begin
    if (!rst_n)            stage <= CS_IDLE;
    else if (setup_ep0)    stage <= setup_read ? CS_READ : CS_WRITE;
    else if (status_done)  stage <= CS_IDLE;
  end

  assert_status_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_done && !setup_ep0) |=> (stage == CS_IDLE));

  assert_setup_opens_transfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    setup_ep0 |=> (stage != CS_IDLE));

endmodule

// File: rtl/hs_toggle_bank.sv
module hs_toggle_bank #(
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:1] ep_enable,
  input  logic              setup_ep0,
  input  logic [NUM_EP-1:0] flip,
  output logic [NUM_EP-1:0] tgl
);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_tgl
    if (i == 0) begin : g_ctl
      always_ff @(posedge clk) begin
        if (!rst_n)          tgl[i] <= 1'b0;
        else if (setup_ep0)  tgl[i] <= 1'b1;
        else if (flip[i])    tgl[i] <= ~tgl[i];
      end
    end else begin : g_data
      always_ff @(posedge clk) begin
        if (!rst_n)              tgl[i] <= 1'b0;
        else if (!ep_enable[i])  tgl[i] <= 1'b0;
        else if (flip[i])        tgl[i] <= ~tgl[i];
      end

      assert_disable_clears_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_enable[i] |=> !tgl[i]);
    end
  end

endmodule

// File: rtl/ctl_handshake_unit.sv
module ctl_handshake_unit
  import hs_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EPW    = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fw_we,
  input  logic [EPW-1:0]    fw_ep,
  input  logic              fw_dsen,
  input  logic              fw_status,
  input  logic              fw_stall_set,
  input  logic              fw_stall_clr,
  input  logic [EPW-1:0]    rd_ep,
  output logic [2:0]        rd_bits,
  input  logic [NUM_EP-1:1] ep_enable,
  input  logic [NUM_EP-1:1] ep_iso,
  input  logic [NUM_EP-1:0] tx_ready,
  input  logic [NUM_EP-1:0] rx_room,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic [EPW-1:0]    tok_ep,
  input  logic              tok_read_dir,
  input  logic              host_ack,
  output logic              hs_valid,
  output logic [1:0]        hs_code,
  output logic              hs_toggle
);

  logic [NUM_EP-1:0] stall;
  logic              dsen0;
  logic              status0;
  ctl_stage_e        stage;
  logic [NUM_EP-1:0] tgl;
  logic [NUM_EP-1:0] flip;

  logic              resp_valid;
  hs_code_e          resp_code;
  logic              resp_toggle;
  hs_event_t         ev;

  // Record of the last packet sent, waiting for the host's acknowledge
  logic              pend;
  logic              pend_zlp;
  logic [EPW-1:0]    pend_ep;
  logic              ack_data;
  logic              ack_zlp;
  logic              dsen_clr;
  logic              status_done;

  assign ack_data    = host_ack && pend && !pend_zlp;
  assign ack_zlp     = host_ack && pend && pend_zlp;
  assign dsen_clr    = (ev.out_data_ack && tok_ep == '0) || (ack_data && pend_ep == '0);
  assign status_done = ev.status_out_done || ack_zlp;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_flip
    assign flip[i] = (ev.out_data_ack && tok_ep == EPW'(i))
                   ^ (ack_data && pend_ep == EPW'(i));
  end

  hs_decide #(.NUM_EP(NUM_EP), .EPW(EPW)) u_decide (
    .tok_valid   (tok_valid),
    .tok_kind    (tok_kind),
    .tok_ep      (tok_ep),
    .ep_enable   (ep_enable),
    .ep_iso      (ep_iso),
    .tx_ready    (tx_ready),
    .rx_room     (rx_room),
    .stall       (stall),
    .dsen0       (dsen0),
    .status0     (status0),
    .stage       (stage),
    .tgl         (tgl),
    .resp_valid  (resp_valid),
    .resp_code   (resp_code),
    .resp_toggle (resp_toggle),
    .ev          (ev)
  );

  hs_cmd_bank #(.NUM_EP(NUM_EP), .EPW(EPW)) u_cmd (
    .clk          (clk),
    .rst_n        (rst_n),
    .fw_we        (fw_we),
    .fw_ep        (fw_ep),
    .fw_dsen      (fw_dsen),
    .fw_status    (fw_status),
    .fw_stall_set (fw_stall_set),
    .fw_stall_clr (fw_stall_clr),
    .setup_ep0    (ev.setup_ep0),
    .dsen_clr     (dsen_clr),
    .status_clr   (status_done),
    .stall        (stall),
    .dsen0        (dsen0),
    .status0      (status0)
  );

  hs_ctl_stage u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .setup_ep0   (ev.setup_ep0),
    .setup_read  (tok_read_dir),
    .status_done (status_done),
    .stage       (stage)
  );

  hs_toggle_bank #(.NUM_EP(NUM_EP)) u_tgl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ep_enable (ep_enable),
    .setup_ep0 (ev.setup_ep0),
    .flip      (flip),
    .tgl       (tgl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      pend_zlp <= 1'b0;
      pend_ep  <= '0;
    end else if (resp_valid) begin
      pend     <= ev.in_data || ev.in_zlp;
      pend_zlp <= ev.in_zlp;
      pend_ep  <= tok_ep;
    end else if (host_ack) begin
      pend     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_valid  <= 1'b0;
      hs_code   <= 2'b00;
      hs_toggle <= 1'b0;
    end else begin
      hs_valid  <= resp_valid;
      hs_code   <= resp_valid ? resp_code : HS_NAK;
      hs_toggle <= resp_valid && resp_toggle;
    end
  end

  // Data-stage enable is write-only; status exists on the control endpoint only
  assign rd_bits = {1'b0, (rd_ep == '0) && status0, stall[rd_ep]};

  logic [NUM_EP-1:0] chk_en;
  logic [NUM_EP-1:0] chk_iso;
  assign chk_en  = {ep_enable, 1'b1};
  assign chk_iso = {ep_iso, 1'b0};

  assert_token_answered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind != TK_RSVD) |=> hs_valid);

  assert_reserved_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == TK_RSVD) |=> !hs_valid);

  assert_setup_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == TK_SETUP && tok_ep == '0) |=> (hs_code == HS_ACK));

  assert_dsen_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == TK_OUT && tok_ep == '0 && !dsen0 && stage == CS_WRITE)
      |=> (hs_code != HS_ACK));

  assert_status_nak_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == TK_IN && tok_ep == '0 && !stall[0] && !status0
      && stage == CS_WRITE) |=> (hs_code == HS_NAK));

  assert_stall_answer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind != TK_SETUP && tok_kind != TK_RSVD && chk_en[tok_ep]
      && stall[tok_ep] && !chk_iso[tok_ep]) |=> (hs_code == HS_STALL));

  assert_no_toggle_on_nak_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_code == HS_NAK || hs_code == HS_STALL) |-> !hs_toggle);

endmodule

// File: tb/ctl_handshake_unit_tb_top.sv
`timescale 1ns/1ps
module ctl_handshake_unit_tb_top;

  localparam int NUM_EP = 4;
  localparam int EPW    = 2;
  localparam int NV     = 51;

  // Vector layout: op[31:28] ep[27:26] arg[25:20] exp_code[19:18] exp_tgl[17] req[3:0]
  // op 0 firmware write  arg {stall_clr, stall_set, status, dsen}
  // op 1 token, checked  arg {read_dir, kind[1:0]}
  // op 2 host acknowledge
  // op 3 endpoint config arg {rx_room, tx_ready, iso, enable}
  // op 4 token expecting no answer
  localparam logic [31:0] VEC [NV] = '{
    {4'd3, 2'd0, 6'd13, 2'd0, 1'b0, 13'd0, 4'd9 },  // R9 cfg ep0 tx+rx
    {4'd1, 2'd0, 6'd1,  2'd0, 1'b0, 13'd0, 4'd7 },  // R7 IN before any SETUP: NAK
    {4'd1, 2'd0, 6'd0,  2'd1, 1'b0, 13'd0, 4'd3 },  // R3 SETUP write transfer
    {4'd1, 2'd0, 6'd2,  2'd0, 1'b0, 13'd0, 4'd4 },  // R4 OUT without enable: NAK
    {4'd0, 2'd0, 6'd1,  2'd0, 1'b0, 13'd0, 4'd4 },  // R4 set data-stage enable
    {4'd1, 2'd0, 6'd2,  2'd1, 1'b0, 13'd0, 4'd4 },  // R4 OUT accepted
    {4'd1, 2'd0, 6'd2,  2'd0, 1'b0, 13'd0, 4'd4 },  // R4 enable consumed: NAK
    {4'd1, 2'd0, 6'd1,  2'd0, 1'b0, 13'd0, 4'd6 },  // R6 status IN, ack bit 0: NAK
    {4'd0, 2'd0, 6'd2,  2'd0, 1'b0, 13'd0, 4'd6 },  // R6 set status ack
    {4'd1, 2'd0, 6'd1,  2'd2, 1'b1, 13'd0, 4'd6 },  // R6 ZLP with toggle 1
    {4'd2, 2'd0, 6'd0,  2'd0, 1'b0, 13'd0, 4'd7 },  // R7 host ack of ZLP
    {4'd1, 2'd0, 6'd1,  2'd0, 1'b0, 13'd0, 4'd7 },  // R7 idle again: NAK
    {4'd1, 2'd0, 6'd4,  2'd1, 1'b0, 13'd0, 4'd3 },  // R3 SETUP read transfer
    {4'd1, 2'd0, 6'd1,  2'd0, 1'b0, 13'd0, 4'd5 },  // R5 IN without enable: NAK
    {4'd0, 2'd0, 6'd1,  2'd0, 1'b0, 13'd0, 4'd5 },  // R5 set enable
    {4'd1, 2'd0, 6'd1,  2'd1, 1'b1, 13'd0, 4'd10},  // R10 first data after SETUP: toggle 1
    {4'd2, 2'd0, 6'd0,  2'd0, 1'b0, 13'd0, 4'd5 },  // R5 host ack clears enable
    {4'd1, 2'd0, 6'd1,  2'd0, 1'b0, 13'd0, 4'd5 },  // R5 NAK after clear
    {4'd0, 2'd0, 6'd1,  2'd0, 1'b0, 13'd0, 4'd5 },  // R5 set enable again
    {4'd1, 2'd0, 6'd1,  2'd1, 1'b0, 13'd0, 4'd10},  // R10 second data: toggle 0
    {4'd2, 2'd0, 6'd0,  2'd0, 1'b0, 13'd0, 4'd10},  // R10 host ack
    {4'd1, 2'd0, 6'd2,  2'd0, 1'b0, 13'd0, 4'd6 },  // R6 status OUT, ack bit 0: NAK
    {4'd0, 2'd0, 6'd2,  2'd0, 1'b0, 13'd0, 4'd6 },  // R6 set status ack
    {4'd1, 2'd0, 6'd2,  2'd1, 1'b0, 13'd0, 4'd6 },  // R6 status OUT ACK
    {4'd1, 2'd0, 6'd2,  2'd0, 1'b0, 13'd0, 4'd7 },  // R7 transfer done: NAK
    {4'd0, 2'd0, 6'd4,  2'd0, 1'b0, 13'd0, 4'd8 },  // R8 stall ep0
    {4'd1, 2'd0, 6'd1,  2'd3, 1'b0, 13'd0, 4'd8 },  // R8 IN stalled
    {4'd1, 2'd0, 6'd0,  2'd1, 1'b0, 13'd0, 4'd3 },  // R3 SETUP accepted while stalled
    {4'd1, 2'd0, 6'd1,  2'd0, 1'b0, 13'd0, 4'd3 },  // R3 stall gone: NAK
    {4'd0, 2'd0, 6'd2,  2'd0, 1'b0, 13'd0, 4'd6 },  // R6 status right after SETUP
    {4'd1, 2'd0, 6'd1,  2'd2, 1'b1, 13'd0, 4'd6 },  // R6 no-data ZLP
    {4'd2, 2'd0, 6'd0,  2'd0, 1'b0, 13'd0, 4'd7 },  // R7 host ack
    {4'd1, 2'd1, 6'd1,  2'd0, 1'b0, 13'd0, 4'd9 },  // R9 disabled ep1: NAK
    {4'd3, 2'd1, 6'd5,  2'd0, 1'b0, 13'd0, 4'd9 },  // R9 enable ep1 with tx data
    {4'd1, 2'd1, 6'd1,  2'd1, 1'b0, 13'd0, 4'd9 },  // R9 data, toggle 0
    {4'd2, 2'd0, 6'd0,  2'd0, 1'b0, 13'd0, 4'd10},  // R10 host ack flips
    {4'd1, 2'd1, 6'd1,  2'd1, 1'b1, 13'd0, 4'd10},  // R10 data, toggle 1
    {4'd0, 2'd1, 6'd4,  2'd0, 1'b0, 13'd0, 4'd8 },  // R8 stall ep1
    {4'd1, 2'd1, 6'd1,  2'd3, 1'b0, 13'd0, 4'd8 },  // R8 IN stalled
    {4'd1, 2'd1, 6'd2,  2'd3, 1'b0, 13'd0, 4'd8 },  // R8 OUT stalled
    {4'd0, 2'd1, 6'd8,  2'd0, 1'b0, 13'd0, 4'd8 },  // R8 clear stall
    {4'd1, 2'd1, 6'd1,  2'd1, 1'b1, 13'd0, 4'd10},  // R10 stall kept toggle 1
    {4'd3, 2'd1, 6'd4,  2'd0, 1'b0, 13'd0, 4'd10},  // R10 disable ep1
    {4'd3, 2'd1, 6'd5,  2'd0, 1'b0, 13'd0, 4'd10},  // R10 re-enable ep1
    {4'd1, 2'd1, 6'd1,  2'd1, 1'b0, 13'd0, 4'd10},  // R10 toggle back to 0
    {4'd1, 2'd1, 6'd2,  2'd0, 1'b0, 13'd0, 4'd9 },  // R9 OUT without room: NAK
    {4'd3, 2'd2, 6'd11, 2'd0, 1'b0, 13'd0, 4'd8 },  // R8 ep2 enabled, iso, rx room
    {4'd0, 2'd2, 6'd4,  2'd0, 1'b0, 13'd0, 4'd8 },  // R8 stall iso ep2
    {4'd1, 2'd2, 6'd2,  2'd1, 1'b0, 13'd0, 4'd8 },  // R8 stall ignored on iso
    {4'd1, 2'd2, 6'd0,  2'd3, 1'b0, 13'd0, 4'd3 },  // R3 SETUP on data ep: STALL
    {4'd4, 2'd0, 6'd3,  2'd0, 1'b0, 13'd0, 4'd1 }   // R1 reserved kind: silent
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              fw_we, fw_dsen, fw_status, fw_stall_set, fw_stall_clr;
  logic [EPW-1:0]    fw_ep, rd_ep, tok_ep;
  logic [2:0]        rd_bits;
  logic [NUM_EP-1:0] cfg_en, cfg_iso, tx_ready, rx_room;
  logic              tok_valid, tok_read_dir, host_ack;
  logic [1:0]        tok_kind;
  logic              hs_valid, hs_toggle;
  logic [1:0]        hs_code;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  ctl_handshake_unit #(.NUM_EP(NUM_EP)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .fw_we(fw_we), .fw_ep(fw_ep), .fw_dsen(fw_dsen), .fw_status(fw_status),
    .fw_stall_set(fw_stall_set), .fw_stall_clr(fw_stall_clr),
    .rd_ep(rd_ep), .rd_bits(rd_bits),
    .ep_enable(cfg_en[NUM_EP-1:1]), .ep_iso(cfg_iso[NUM_EP-1:1]),
    .tx_ready(tx_ready), .rx_room(rx_room),
    .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_ep(tok_ep),
    .tok_read_dir(tok_read_dir), .host_ack(host_ack),
    .hs_valid(hs_valid), .hs_code(hs_code), .hs_toggle(hs_toggle)
  );

  task automatic chk(input bit ok, input int req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus; returns on the falling edge after the capturing edge
  task automatic cyc(input logic tv, input logic [1:0] tk, input logic [EPW-1:0] te,
                     input logic td, input logic fv, input logic [EPW-1:0] fe,
                     input logic [3:0] fb, input logic ha);
    @(negedge clk);
    tok_valid = tv; tok_kind = tk; tok_ep = te; tok_read_dir = td;
    fw_we = fv; fw_ep = fe;
    fw_dsen = fb[0]; fw_status = fb[1]; fw_stall_set = fb[2]; fw_stall_clr = fb[3];
    host_ack = ha;
    @(negedge clk);
    tok_valid = 1'b0; fw_we = 1'b0; host_ack = 1'b0;
    fw_dsen = 1'b0; fw_status = 1'b0; fw_stall_set = 1'b0; fw_stall_clr = 1'b0;
  endtask

  task automatic expect_hs(input int req, input string what,
                           input logic [1:0] code, input logic tg);
    chk(hs_valid && hs_code == code && hs_toggle == tg, req, what,
        {hs_valid, hs_code, hs_toggle}, {1'b1, code, tg});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL R1 watchdog expired: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    fw_we = 0; fw_ep = 0; fw_dsen = 0; fw_status = 0; fw_stall_set = 0; fw_stall_clr = 0;
    rd_ep = 0; cfg_en = 0; cfg_iso = 0; tx_ready = 0; rx_room = 0;
    tok_valid = 0; tok_kind = 0; tok_ep = 0; tok_read_dir = 0; host_ack = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state: no answer, all command bits clear (R1, R11)
    chk(hs_valid == 1'b0, 1, "reset hs_valid", hs_valid, 0);
    rd_ep = 0; #0.1;
    chk(rd_bits == 3'b000, 11, "reset readback ep0", rd_bits, 0);

    for (int k = 0; k < NV; k++) begin
      automatic logic [31:0]    v   = VEC[k];
      automatic logic [3:0]     op  = v[31:28];
      automatic logic [EPW-1:0] ep  = v[27:26];
      automatic logic [5:0]     arg = v[25:20];
      automatic logic [1:0]     ec  = v[19:18];
      automatic logic           et  = v[17];
      automatic int             rq  = int'(v[3:0]);
      case (op)
        4'd0: cyc(1'b0, 2'b00, '0, 1'b0, 1'b1, ep, arg[3:0], 1'b0);
        4'd1: begin
          cyc(1'b1, arg[1:0], ep, arg[2], 1'b0, '0, 4'b0, 1'b0);
          expect_hs(rq, $sformatf("vector %0d", k), ec, et);
        end
        4'd2: cyc(1'b0, 2'b00, '0, 1'b0, 1'b0, '0, 4'b0, 1'b1);
        4'd3: begin
          @(negedge clk);
          cfg_en[ep] = arg[0]; cfg_iso[ep] = arg[1];
          tx_ready[ep] = arg[2]; rx_room[ep] = arg[3];
          @(negedge clk);
        end
        default: begin
          cyc(1'b1, arg[1:0], ep, 1'b0, 1'b0, '0, 4'b0, 1'b0);
          chk(hs_valid == 1'b0, rq, $sformatf("vector %0d silent", k), hs_valid, 0);
        end
      endcase
    end

    // R11: data-stage enable never reads back; status only on ep0
    cyc(1'b0, 2'b00, '0, 1'b0, 1'b1, 2'd0, 4'b0011, 1'b0);
    rd_ep = 0; #0.1;
    chk(rd_bits == 3'b010, 11, "readback ep0 after dsen+status", rd_bits, 2);
    cyc(1'b0, 2'b00, '0, 1'b0, 1'b1, 2'd1, 4'b0010, 1'b0);
    rd_ep = 1; #0.1;
    chk(rd_bits == 3'b000, 11, "readback ep1 status ignored", rd_bits, 0);

    // R12: SETUP on ep0 beats a same-cycle write of status and stall to ep0
    cyc(1'b1, 2'b00, 2'd0, 1'b0, 1'b1, 2'd0, 4'b0110, 1'b0);
    expect_hs(12, "SETUP with same-cycle write", 2'b01, 1'b0);
    rd_ep = 0; #0.1;
    chk(rd_bits == 3'b000, 12, "SETUP overrides firmware write", rd_bits, 0);

    // R12: host ack clearing enable meets a new enable write; write wins
    cyc(1'b1, 2'b00, 2'd0, 1'b1, 1'b0, '0, 4'b0, 1'b0);
    expect_hs(3, "SETUP read transfer", 2'b01, 1'b0);
    cyc(1'b0, 2'b00, '0, 1'b0, 1'b1, 2'd0, 4'b0001, 1'b0);
    cyc(1'b1, 2'b01, 2'd0, 1'b0, 1'b0, '0, 4'b0, 1'b0);
    expect_hs(5, "control IN data", 2'b01, 1'b1);
    cyc(1'b0, 2'b00, '0, 1'b0, 1'b1, 2'd0, 4'b0001, 1'b1);
    cyc(1'b1, 2'b01, 2'd0, 1'b0, 1'b0, '0, 4'b0, 1'b0);
    expect_hs(12, "enable kept after same-cycle ack", 2'b01, 1'b0);

    // R12: stall set and clear together leave stall clear
    cyc(1'b0, 2'b00, '0, 1'b0, 1'b1, 2'd1, 4'b1100, 1'b0);
    rd_ep = 1; #0.1;
    chk(rd_bits == 3'b000, 12, "stall clear beats set", rd_bits, 0);

    // R12: stall write lands after the decision for a same-cycle IN
    cyc(1'b1, 2'b01, 2'd1, 1'b0, 1'b1, 2'd1, 4'b0100, 1'b0);
    expect_hs(12, "IN decided before stall write", 2'b01, 1'b0);
    rd_ep = 1; #0.1;
    chk(rd_bits == 3'b001, 12, "stall visible after write", rd_bits, 1);
    cyc(1'b1, 2'b01, 2'd1, 1'b0, 1'b0, '0, 4'b0, 1'b0);
    expect_hs(8, "next IN stalled", 2'b11, 1'b0);

    // R1: answer lasts one cycle
    @(negedge clk);
    chk(hs_valid == 1'b0, 1, "hs_valid single cycle", hs_valid, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule